// File: doc/BRIEF.md
# Triggerable 8-bit Compare-Match Timer

This block is an 8-bit up-counter with two compare registers and one waveform output. The count clock comes from an internal prescaler (the system clock divided by 4, 8, 16, 32, 64 or 128) or from rising edges on an external clock input. A match on either compare register can clear the counter, raise a status flag and apply an action to the output: set it, clear it, toggle it, or leave it alone. Because each compare register has its own action, one compare register can set the period and the other the pulse width, which gives a PWM output with any duty cycle.

Counting can also be held off until an edge arrives on a trigger input. If the trigger mode is combined with clearing on compare A, the counter stops after one period. The block then produces a single pulse, or a pulse delayed from the trigger by a set amount. A compare-A flag, a compare-B flag and an overflow flag each raise a combined interrupt when their enable bits are set. Software reaches the counter, both compare registers, two control registers and the status register through a simple register port with an address, a write strobe and a read path.

The trigger input, the external clock input and the external clear input each pass through two flip-flops before their edges are detected. An event on any of these inputs therefore acts on the counter at the earliest two clock cycles after the pin changes.

Top module: `cm_timer`

## Requirements
- R1: The register port selects registers by address: 0 is the counter, 1 is compare A, 2 is compare B, 3 is control 0, 4 is control 1 and 5 is status. Addresses 6 and 7 read as 0. The counter, compare A and compare B read back the last value written to them. After reset every register reads as 0, and both `wave_out` and `irq` are 0.
- R2: Control 0 bits [2:0] select the count clock:
  - 0 stops the counter.
  - 1 to 6 select the system clock divided by 4, 8, 16, 32, 64 and 128.
  - 7 counts synchronized rising edges of `ext_clk_in`.
  - Edges on `ext_clk_in` are ignored unless 7 is selected.
- R3: A compare event occurs on a count tick during which the counter equals a compare register. An event on A sets status bit 6, and an event on B sets status bit 7.
- R4: A count step from 0xFF to 0x00 sets status bit 5 (overflow). A step to 0 caused by a compare clear does not set this bit.
- R5: `irq` is high when any flag is set together with its enable bit in control 0. The enables are bit 7 for flag B, bit 6 for flag A and bit 5 for overflow.
- R6: Writing 0 to a status flag bit clears that flag, and writing 1 to it leaves the flag unchanged. Status bits [3:0] hold the output-select value, which can be written and read back. If hardware sets a flag in the same cycle that software clears it, the flag is set.
- R7: Control 0 bits [4:3] select how the counter is cleared:
  - 00: the counter is never cleared.
  - 01: the counter is cleared on a compare-A event, in place of the increment.
  - 10: the counter is cleared on a compare-B event, in place of the increment.
  - 11: the counter is cleared on a synchronized rising edge of `ext_clr_in`.
  - `ext_clr_in` is ignored for any other setting.
- R8: Output-select bits [1:0] give the action on a compare-A event, and bits [3:2] give the action on a compare-B event. The codes are 00 = none, 01 = clear, 10 = set and 11 = toggle. If both events occur in the same cycle, the B action applies unless it is 00.
- R9: With the counter cleared on A, set-on-A and clear-on-B, and a prescaler divide of N, `wave_out` has a period of (A+1)·N cycles and a high time of (B+1)·N cycles. Toggle-on-B with the counter cleared on B gives a period of 2·(B+1)·N cycles.
- R10: Control 1 bit 0 enables triggered counting, and bits [2:1] select the trigger edge: 00 = rising, 01 = falling, 1x = both. While triggered counting is enabled, the counter holds its value until the selected edge of `trig_in` arrives. Edges of the kind not selected are ignored.
- R11: In triggered mode, when the counter is cleared on compare A, a compare-A event also stops counting. Counting stays stopped until the next selected trigger edge, so each trigger produces exactly one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe; `reg_wdata` is written at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| trig_in | input | 1 | Asynchronous trigger input |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| ext_clr_in | input | 1 | Asynchronous external counter clear |
| wave_out | output | 1 | Compare-driven waveform output |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach is the one-shot sequence. Triggered counting must be enabled while the trigger pin already sits at a level that is not a valid edge. The counter must then be shown to stay frozen through an ignored edge, to run exactly one compare-A period after the valid edge, and to stay parked at zero afterwards. The stimulus reaches this by driving the trigger pin to a chosen level before triggered mode is enabled, then switching the edge selection between rising, falling and both. Each step is checked through counter reads and the compare-A flag. Conflicting compare actions are reached by giving A and B the same value, and the random PWM cases draw compare values and prescaler settings from a fixed seed.

// File: rtl/tmr_pkg.sv
// Package: shared encodings for the compare-match timer.
// Assumes: a 3-bit register address space and 2-bit action and clear fields.
package tmr_pkg;

    // Register addresses on the register port
    localparam logic [2:0] ADDR_CNT   = 3'd0;
    localparam logic [2:0] ADDR_CMPA  = 3'd1;
    localparam logic [2:0] ADDR_CMPB  = 3'd2;
    localparam logic [2:0] ADDR_CTRL0 = 3'd3;
    localparam logic [2:0] ADDR_CTRL1 = 3'd4;
    localparam logic [2:0] ADDR_STAT  = 3'd5;

    // Action that a compare event applies to the waveform output
    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } out_act_e;

    // Source that clears the counter
    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_CMPA = 2'b01,
        CLR_CMPB = 2'b10,
        CLR_EXT  = 2'b11
    } clr_src_e;

    // Trigger edge selection
    typedef enum logic [1:0] {
        TEDGE_RISE = 2'b00,
        TEDGE_FALL = 2'b01,
        TEDGE_BOTH = 2'b10,
        TEDGE_ANY  = 2'b11
    } trig_edge_e;

endpackage

// File: rtl/tmr_edge_sync.sv
// Module: tmr_edge_sync
// Brings one asynchronous pin into the clock domain through a chain of
// STAGES flip-flops and gives a one-cycle pulse for each rising and each
// falling edge of the synchronized level.
// Assumes: the pin holds each level for at least STAGES+1 clock cycles.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer and keep the last synced level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

    // An edge pulse never lasts more than one cycle (R2, R7, R10)
    assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall));

endmodule

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Free-running divider that gives one-cycle tick pulses at the system clock
// divided by 2**MIN_LOG, 2**(MIN_LOG+1), ... for STEPS settings.
// Assumes: the consumer picks one tick line; ticks are periodic from reset.
module tmr_prescaler #(
    parameter int STEPS   = 6,
    parameter int MIN_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [STEPS-1:0] ticks
);

    localparam int PRE_W = MIN_LOG + STEPS - 1;

    logic [PRE_W-1:0] pre_q;

    // Advance the free-running divider counter
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar k = 0; k < STEPS; k++) begin : g_tick
        assign ticks[k] = &pre_q[MIN_LOG+k-1:0];
    end

    // The fastest tick never fires in two consecutive cycles (R2)
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ticks[0] |=> !ticks[0]);

endmodule

// File: rtl/tmr_wave_out.sv
// Module: tmr_wave_out
// Holds the waveform output and applies the actions of compare events.
// If both events occur in the same cycle, the B action applies unless it
// is "none".
// Assumes: each event input is a single-cycle pulse aligned to a count tick.
module tmr_wave_out
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt_a,
    input  logic     evt_b,
    input  out_act_e act_a,
    input  out_act_e act_b,
    output logic     wave
);

    out_act_e act_sel;
    logic     wave_d;

    // Choose the action that wins this cycle
    always_comb begin
        act_sel = ACT_NONE;
        if (evt_b && act_b != ACT_NONE) act_sel = act_b;
        else if (evt_a)                 act_sel = act_a;
    end

    // Work out the next output level from the winning action
    always_comb begin
        case (act_sel)
            ACT_CLR: wave_d = 1'b0;
            ACT_SET: wave_d = 1'b1;
            ACT_TGL: wave_d = ~wave;
            default: wave_d = wave;
        endcase
    end

    // Register the output level
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= wave_d;
    end

    // A set on A with no competing B action drives the output high (R8)
    assert_set_on_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_a && act_a == ACT_SET && !(evt_b && act_b != ACT_NONE)) |=> wave);

    // A clear on B always wins (R8)
    assert_b_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_b && act_b == ACT_CLR) |=> !wave);

endmodule

// File: rtl/cm_timer.sv
// Module: cm_timer (top)
// 8-bit compare-match timer. The count clock is prescaled or external, the
// clear source is selectable, the start can be gated by a trigger edge, and
// one waveform output is driven by per-compare actions. Status flags feed a
// combined interrupt.
// Assumes: the register port is written one register per cycle, and reads
// are combinational. CNT_W is at least 8 because the control fields sit in
// the low byte.
module cm_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_STEPS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             trig_in,
    input  logic             ext_clk_in,
    input  logic             ext_clr_in,
    output logic             wave_out,
    output logic             irq
);

    localparam int                SEL_W   = 3;
    localparam int                N_PINS  = 3;
    localparam int                PIN_TRG = 2;
    localparam int                PIN_CLK = 1;
    localparam int                PIN_CLR = 0;
    localparam logic [SEL_W-1:0]  SEL_EXT = SEL_W'(PRE_STEPS + 1);

    // ---------------- register state ----------------
    logic [CNT_W-1:0] cnt_q, cmp_a_q, cmp_b_q;
    logic             ie_b_q, ie_a_q, ie_ov_q;
    clr_src_e         clr_q;
    logic [SEL_W-1:0] sel_q;
    logic             trg_en_q;
    trig_edge_e       trg_edge_q;
    logic             cmfa_q, cmfb_q, ovf_q;
    logic [3:0]       os_q;
    logic             run_q;

    // ---------------- write decode ----------------
    logic wr_cnt, wr_cmpa, wr_cmpb, wr_ctrl0, wr_ctrl1, wr_stat;
    assign wr_cnt   = reg_wr && reg_addr == ADDR_CNT;
    assign wr_cmpa  = reg_wr && reg_addr == ADDR_CMPA;
    assign wr_cmpb  = reg_wr && reg_addr == ADDR_CMPB;
    assign wr_ctrl0 = reg_wr && reg_addr == ADDR_CTRL0;
    assign wr_ctrl1 = reg_wr && reg_addr == ADDR_CTRL1;
    assign wr_stat  = reg_wr && reg_addr == ADDR_STAT;

    logic wdata_unused;
    assign wdata_unused = ^reg_wdata[CNT_W-1:3];

    // ---------------- pin synchronizers ----------------
    logic [N_PINS-1:0] pins, edge_rise, edge_fall;
    logic              fall_unused;
    assign pins        = {trig_in, ext_clk_in, ext_clr_in};
    assign fall_unused = ^edge_fall[PIN_CLK:PIN_CLR];

    for (genvar i = 0; i < N_PINS; i++) begin : g_sync
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[i]),
            .rise (edge_rise[i]),
            .fall (edge_fall[i])
        );
    end

    // ---------------- prescaler and clock select ----------------
    logic [PRE_STEPS-1:0] pre_ticks;
    logic                 tick;

    tmr_prescaler #(.STEPS(PRE_STEPS), .MIN_LOG(2)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .ticks(pre_ticks)
    );

    // Pick the count tick named by the clock-select field
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < PRE_STEPS; k++) begin
            if (sel_q == SEL_W'(k + 1)) tick = pre_ticks[k];
        end
        if (sel_q == SEL_EXT) tick = edge_rise[PIN_CLK];
    end

    // ---------------- counting control ----------------
    logic trig_hit, running, count_en, evt_a, evt_b, clr_by_cmp, ext_clr_hit, wrap;

    // Detect the selected trigger edge
    always_comb begin
        case (trg_edge_q)
            TEDGE_RISE: trig_hit = edge_rise[PIN_TRG];
            TEDGE_FALL: trig_hit = edge_fall[PIN_TRG];
            default:    trig_hit = edge_rise[PIN_TRG] | edge_fall[PIN_TRG];
        endcase
    end

    assign running     = trg_en_q ? run_q : 1'b1;
    assign count_en    = tick && running;
    assign evt_a       = count_en && (cnt_q == cmp_a_q);
    assign evt_b       = count_en && (cnt_q == cmp_b_q);
    assign clr_by_cmp  = (clr_q == CLR_CMPA && evt_a) || (clr_q == CLR_CMPB && evt_b);
    assign ext_clr_hit = (clr_q == CLR_EXT) && edge_rise[PIN_CLR];
    assign wrap        = count_en && !clr_by_cmp && (cnt_q == {CNT_W{1'b1}});

    // Update the counter: software write, then clears, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (wr_cnt)                     cnt_q <= reg_wdata;
        else if (ext_clr_hit || clr_by_cmp)  cnt_q <= '0;
        else if (count_en)                   cnt_q <= cnt_q + 1'b1;
    end

    // Start on a trigger edge; stop after a compare-A clear in triggered mode
    always_ff @(posedge clk) begin
        if (!rst_n)                              run_q <= 1'b0;
        else if (!trg_en_q)                      run_q <= 1'b0;
        else if (trig_hit)                       run_q <= 1'b1;
        else if (clr_q == CLR_CMPA && evt_a)     run_q <= 1'b0;
    end

    // Hold the compare and control registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a_q    <= '0;
            cmp_b_q    <= '0;
            ie_b_q     <= 1'b0;
            ie_a_q     <= 1'b0;
            ie_ov_q    <= 1'b0;
            clr_q      <= CLR_NONE;
            sel_q      <= '0;
            trg_en_q   <= 1'b0;
            trg_edge_q <= TEDGE_RISE;
            os_q       <= '0;
        end else begin
            if (wr_cmpa) cmp_a_q <= reg_wdata;
            if (wr_cmpb) cmp_b_q <= reg_wdata;
            if (wr_ctrl0) begin
                ie_b_q  <= reg_wdata[7];
                ie_a_q  <= reg_wdata[6];
                ie_ov_q <= reg_wdata[5];
                clr_q   <= clr_src_e'(reg_wdata[4:3]);
                sel_q   <= reg_wdata[2:0];
            end
            if (wr_ctrl1) begin
                trg_en_q   <= reg_wdata[0];
                trg_edge_q <= trig_edge_e'(reg_wdata[2:1]);
            end
            if (wr_stat) os_q <= reg_wdata[3:0];
        end
    end

    // Set flags on events; a software 0 clears them, hardware set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmfa_q <= 1'b0;
            cmfb_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (evt_a)                          cmfa_q <= 1'b1;
            else if (wr_stat && !reg_wdata[6])  cmfa_q <= 1'b0;
            if (evt_b)                          cmfb_q <= 1'b1;
            else if (wr_stat && !reg_wdata[7])  cmfb_q <= 1'b0;
            if (wrap)                           ovf_q  <= 1'b1;
            else if (wr_stat && !reg_wdata[5])  ovf_q  <= 1'b0;
        end
    end

    assign irq = (cmfa_q & ie_a_q) | (cmfb_q & ie_b_q) | (ovf_q & ie_ov_q);

    // ---------------- waveform output ----------------
    tmr_wave_out u_wave (
        .clk  (clk),
        .rst_n(rst_n),
        .evt_a(evt_a),
        .evt_b(evt_b),
        .act_a(out_act_e'(os_q[1:0])),
        .act_b(out_act_e'(os_q[3:2])),
        .wave (wave_out)
    );

    // ---------------- read path ----------------
    // Return the register at the selected address
    always_comb begin
        case (reg_addr)
            ADDR_CNT:   reg_rdata = cnt_q;
            ADDR_CMPA:  reg_rdata = cmp_a_q;
            ADDR_CMPB:  reg_rdata = cmp_b_q;
            ADDR_CTRL0: reg_rdata = CNT_W'({ie_b_q, ie_a_q, ie_ov_q, clr_q, sel_q});
            ADDR_CTRL1: reg_rdata = CNT_W'({trg_edge_q, trg_en_q});
            ADDR_STAT:  reg_rdata = CNT_W'({cmfb_q, cmfa_q, ovf_q, 1'b0, os_q});
            default:    reg_rdata = '0;
        endcase
    end

    // ---------------- assertions ----------------
    // A compare clear leaves the counter at zero (R7)
    assert_cmp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_by_cmp && !wr_cnt) |=> (cnt_q == '0));

    // A wrap raises the overflow flag (R4)
    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);

    // Armed but not started: the counter holds (R10)
    assert_hold_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_en_q && !run_q && !trig_hit && !wr_cnt && !ext_clr_hit) |=> $stable(cnt_q));

    // A one-shot stops after its compare-A clear (R11)
    assert_oneshot_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_en_q && clr_q == CLR_CMPA && evt_a && !trig_hit) |=> !run_q);

    // No interrupt while all enables are off (R5)
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_a_q && !ie_b_q && !ie_ov_q) |-> !irq);

endmodule

// File: tb/sim_cm_timer.sv
// Bench for cm_timer: directed corner cases mixed with seeded random PWM
// settings, checked against values computed from the requirements.
module sim_cm_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       trig_in = 1'b0, ext_clk_in = 1'b0, ext_clr_in = 1'b0;
    logic       wave_out, irq;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cm_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .ext_clk_in(ext_clk_in), .ext_clr_in(ext_clr_in),
        .wave_out(wave_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected prescaler divide for a clock-select code 1..6
    function automatic int div_of(input int sel);
        return 4 << (sel - 1);
    endfunction

    // Wait for a rising edge of wave_out, then measure high time and period
    task automatic measure(input int limit, output int hi, output int per);
        logic prev;
        int   guard;
        hi = 0; per = 0; guard = 0;
        @(negedge clk); prev = wave_out;
        while (!(prev == 1'b0 && wave_out == 1'b1) && guard < limit) begin
            prev = wave_out;
            @(negedge clk);
            guard++;
        end
        do begin @(negedge clk); hi++; end while (wave_out == 1'b1 && hi < limit);
        per = hi;
        do begin @(negedge clk); per++; end while (wave_out == 1'b0 && per < 2*limit);
    endtask

    task automatic pulse(ref logic p, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); p = 1'b1; idle(3);
            p = 1'b0; idle(3);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before the run ended (all requirements)");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int hi, per;
        void'($urandom(32'd5150));
        idle(3);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk($sformatf("R1 reset read addr %0d", a), d, 0);
        end
        chk("R1 reset wave_out", wave_out, 0);
        chk("R1 reset irq", irq, 0);

        // R1: random read-back with the clock stopped
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            wr(3'd0, v); rd(3'd0, d); chk("R1 counter readback", d, v);
            v = 8'($urandom);
            wr(3'd1, v); rd(3'd1, d); chk("R1 compare A readback", d, v);
            v = 8'($urandom);
            wr(3'd2, v); rd(3'd2, d); chk("R1 compare B readback", d, v);
        end

        // R9/R2/R8: random PWM, set on A, clear on B, cleared on A
        for (int i = 0; i < 4; i++) begin
            int sel, a, b;
            sel = 1 + int'($urandom % 3);
            a   = 8 + int'($urandom % 40);
            b   = int'($urandom % (a - 1));
            wr(3'd3, 8'h00);
            wr(3'd5, 8'h00);
            wr(3'd1, 8'(a));
            wr(3'd2, 8'(b));
            wr(3'd0, 8'h00);
            wr(3'd5, 8'h06);
            wr(3'd3, 8'(8'h08 | sel));
            measure((a + 1) * div_of(sel) * 3, hi, per);
            chk($sformatf("R9 high time sel=%0d A=%0d B=%0d", sel, a, b), hi, (b + 1) * div_of(sel));
            chk($sformatf("R9 period sel=%0d A=%0d", sel, a), per, (a + 1) * div_of(sel));
        end

        // R3: both compare flags set after PWM running; R6 flag clear rules
        wr(3'd3, 8'h00);
        rd(3'd5, d);
        chk("R3 flags A and B set, no overflow", d, 8'hC6);
        wr(3'd5, 8'h46);
        rd(3'd5, d);
        chk("R6 write 1 keeps A, write 0 clears B", d, 8'h46);
        wr(3'd5, 8'h09);
        rd(3'd5, d);
        chk("R6 all flags cleared, output select written", d, 8'h09);

        // R4/R5: overflow flag and its interrupt enable
        wr(3'd5, 8'h00);
        wr(3'd0, 8'hFD);
        wr(3'd3, 8'h01);
        idle(24);
        wr(3'd3, 8'h00);
        rd(3'd5, d);
        chk("R4 overflow flag after wrap", d[5], 1);
        chk("R5 irq low with enable off", irq, 0);
        wr(3'd3, 8'h20);
        @(negedge clk);
        chk("R5 irq high with overflow enabled", irq, 1);
        wr(3'd5, 8'h00);
        @(negedge clk);
        chk("R5 irq low after flag cleared", irq, 0);

        // R4: compare clear to zero does not set overflow
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'hFC);
        wr(3'd3, 8'h09);
        idle(30);
        wr(3'd3, 8'h00);
        rd(3'd5, d);
        chk("R4 no overflow on compare clear", d[5], 0);

        // R2: external clock counts rising edges only when selected
        wr(3'd0, 8'h00);
        pulse(ext_clk_in, 3);
        idle(4);
        rd(3'd0, d);
        chk("R2 external edges ignored when stopped", d, 0);
        wr(3'd3, 8'h07);
        pulse(ext_clk_in, 5);
        idle(4);
        wr(3'd3, 8'h00);
        rd(3'd0, d);
        chk("R2 external clock count", d, 5);

        // R7: external clear only when selected
        wr(3'd0, 8'd50);
        pulse(ext_clr_in, 1);
        idle(3);
        rd(3'd0, d);
        chk("R7 external clear ignored", d, 50);
        wr(3'd3, 8'h18);
        pulse(ext_clr_in, 1);
        idle(3);
        rd(3'd0, d);
        chk("R7 external clear", d, 0);

        // R7/R8/R9: clear on B with toggle on B
        wr(3'd3, 8'h00);
        wr(3'd1, 8'd200);
        wr(3'd2, 8'd20);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h0C);
        wr(3'd3, 8'h11);
        measure(400, hi, per);
        chk("R8 toggle on B high time", hi, 84);
        chk("R9 toggle on B period", per, 168);

        // R8: A and B events together, B clear beats A set
        wr(3'd3, 8'h00);
        wr(3'd1, 8'd10);
        wr(3'd2, 8'd10);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h06);
        wr(3'd3, 8'h09);
        idle(60);
        begin
            int highs = 0;
            for (int i = 0; i < 150; i++) begin
                @(negedge clk);
                if (wave_out) highs++;
            end
            chk("R8 B clear wins over A set", highs, 0);
        end
        wr(3'd5, 8'h02);
        idle(60);
        chk("R8 A set applies when B action is none", wave_out, 1);

        // R10/R11: triggered one-shot on rising edges
        wr(3'd3, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'd9);
        wr(3'd2, 8'd200);
        @(negedge clk); trig_in = 1'b1;
        idle(4);
        wr(3'd4, 8'h01);
        wr(3'd3, 8'h09);
        idle(40);
        rd(3'd0, d);
        chk("R10 armed counter holds", d, 0);
        @(negedge clk); trig_in = 1'b0;
        idle(40);
        rd(3'd0, d);
        chk("R10 falling edge ignored in rising mode", d, 0);
        @(negedge clk); trig_in = 1'b1;
        idle(14);
        rd(3'd0, d);
        chk("R10 counting after rising edge", (d >= 1 && d <= 9), 1);
        idle(100);
        rd(3'd0, d);
        chk("R11 one-shot parks at zero", d, 0);
        rd(3'd5, d);
        chk("R11 compare A flag after one-shot", d[6], 1);
        wr(3'd5, 8'h00);
        idle(100);
        rd(3'd5, d);
        chk("R11 stays stopped after one period", d[6], 0);

        // R10: both edges
        wr(3'd4, 8'h05);
        @(negedge clk); trig_in = 1'b0;
        idle(100);
        rd(3'd5, d);
        chk("R10 both-edge mode starts on falling", d[6], 1);

        // R10: falling-only mode ignores rising
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h03);
        @(negedge clk); trig_in = 1'b1;
        idle(100);
        rd(3'd5, d);
        chk("R10 rising ignored in falling mode", d[6], 0);
        @(negedge clk); trig_in = 1'b0;
        idle(100);
        rd(3'd5, d);
        chk("R10 falling starts in falling mode", d[6], 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule